// File: doc/BRIEF.md
# Per-Core Shared Cache Bypass Router

Each core gets one instance of this router. It sits between the core's private first-level cache and the shared second-level cache. Every miss request from the private cache is steered to one of two places. In bypass mode it goes straight to the memory request port, and memory read data comes back to the private cache without passing through the shared cache. In every other mode it goes to the shared cache request port.

The router holds a two-bit capacity code that software writes. Software can read the code back, so the operating system can save and restore it with the program context. The code is turned into a per-way enable mask for a 16-way shared cache. Full capacity enables all ways, half enables the lowest eight, quarter enables the lowest four, and bypass enables none.

Partial capacity is only allowed when this core is running alone. If another core is active, a half or quarter setting is treated as full. The router also raises a low-leakage request for the shared cache when every active core is bypassing it.

Top module: `shc_route_top`

## Requirements
- R1: Right after reset, the capacity code reads back as 2'b00 (full), the way mask has all 16 bits set, and neither request port shows a valid request.
- R2: The capacity code is encoded as 2'b00 full, 2'b01 half, 2'b10 quarter and 2'b11 bypass. With no peer core active, the way mask is 16'hFFFF for full, 16'h00FF for half, 16'h000F for quarter and 16'h0000 for bypass.
- R3: When peer_active is high, a half or quarter code behaves exactly like full: the way mask is 16'hFFFF and requests go to the shared cache port.
- R4: In bypass mode, an L1 request appears on the memory request port with the same address, write flag and write data, and the shared cache request port never has valid set at the same time.
- R5: In full, half or quarter mode, an L1 request appears unchanged on the shared cache request port, and the memory request port stays idle.
- R6: A capacity code written with cfg_wr_en can be read on cfg_rd_code in the next cycle, even while a transaction is outstanding.
- R7: A newly written code becomes active only when no transaction is outstanding. Until it is active, the way mask and the request routing follow the old code, and l1_req_ready stays low.
- R8: A response is taken only from the port that the outstanding request was sent to, even if the code has changed since then. A response that arrives on the other port is not taken: its ready stays low and it is not forwarded.
- R9: sleep_req is high exactly when peer_all_bypass is high and, in addition, either core_active is low or the effective mode of this core is bypass.
- R10: Only one transaction may be outstanding. After an L1 request is accepted, l1_req_ready stays low until the response handshake with L1 has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the capacity code |
| cfg_wr_code | input | 2 | Capacity code to write (full/half/quarter/bypass) |
| cfg_rd_code | output | 2 | Last written capacity code, for context save |
| core_active | input | 1 | This core is running a program |
| peer_active | input | 1 | At least one other core is active |
| peer_all_bypass | input | 1 | Every other active core is in bypass mode |
| l1_req_valid | input | 1 | Miss request valid from L1 |
| l1_req_ready | output | 1 | Miss request accepted |
| l1_req_we | input | 1 | Request is a write |
| l1_req_addr | input | 32 | Request address |
| l1_req_wdata | input | 32 | Write data |
| l2_req_valid | output | 1 | Request valid to the shared cache |
| l2_req_ready | input | 1 | Shared cache accepts the request |
| l2_req_we | output | 1 | Write flag to the shared cache |
| l2_req_addr | output | 32 | Address to the shared cache |
| l2_req_wdata | output | 32 | Write data to the shared cache |
| l2_rsp_valid | input | 1 | Response valid from the shared cache |
| l2_rsp_ready | output | 1 | Shared cache response accepted |
| l2_rsp_data | input | 32 | Shared cache response data |
| mem_req_valid | output | 1 | Request valid to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Write flag to memory |
| mem_req_addr | output | 32 | Address to memory |
| mem_req_wdata | output | 32 | Write data to memory |
| mem_rsp_valid | input | 1 | Response valid from memory |
| mem_rsp_ready | output | 1 | Memory response accepted |
| mem_rsp_data | input | 32 | Memory response data |
| l1_rsp_valid | output | 1 | Response valid to L1 |
| l1_rsp_ready | input | 1 | L1 accepts the response |
| l1_rsp_data | output | 32 | Response data to L1 |
| way_en | output | 16 | Per-way enable mask for the shared cache |
| sleep_req | output | 1 | Request for the shared cache low-leakage state |

## Verification
The hardest case to reach from the ports is a code change that arrives while a request is still waiting for its response, together with a stray response on the port that was not used. The stimulus first sends a request to the shared cache. While the shared cache holds back its response, the stimulus writes the bypass code and drives a memory response at the same time. This checks that the mask and the routing keep the old mode, that the stray memory response is not taken, and that the switch happens only after the shared cache response has completed. After that, a long random phase keeps hitting the same situation: codes are written at random times, peer and ready signals change every cycle, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/shc_route_pkg.sv
package shc_route_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        CAP_FULL    = 2'b00,
        CAP_HALF    = 2'b01,
        CAP_QUARTER = 2'b10,
        CAP_BYPASS  = 2'b11
    } cap_e;

    typedef enum logic {
        PATH_SHARED = 1'b0,
        PATH_MEM    = 1'b1
    } path_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_WAIT = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } miss_req_t;

    // Partial capacity is only legal while this core runs alone.
    function automatic cap_e fold_cap(cap_e code, logic peer);
        if (peer && (code == CAP_HALF || code == CAP_QUARTER))
            return CAP_FULL;
        return code;
    endfunction

    function automatic int unsigned ways_for(cap_e code, int unsigned total);
        case (code)
            CAP_FULL:    return total;
            CAP_HALF:    return total / 2;
            CAP_QUARTER: return total / 4;
            default:     return 0;
        endcase
    endfunction

endpackage

// File: rtl/shc_cfg_reg.sv
module shc_cfg_reg
    import shc_route_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  cap_e wr_code,
    input  logic idle,
    output cap_e pend_code,
    output cap_e act_code,
    output logic switching
);
    cap_e pend_q, act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= CAP_FULL;
            act_q  <= CAP_FULL;
        end else begin
            if (wr_en)
                pend_q <= wr_code;
            if (idle && (pend_q != act_q))
                act_q <= pend_q;
        end
    end

    assign pend_code = pend_q;
    assign act_code  = act_q;
    assign switching = (pend_q != act_q);

    p_readback_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pend_q == $past(wr_code)));

    p_commit_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> $past(idle));

endmodule

// File: rtl/shc_mode_map.sv
module shc_mode_map
    import shc_route_pkg::*;
#(
    parameter int unsigned WAYS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  cap_e            act_code,
    input  logic            core_active,
    input  logic            peer_active,
    input  logic            peer_all_bypass,
    output cap_e            eff_code,
    output logic [WAYS-1:0] way_en,
    output logic            sleep_req
);
    localparam int unsigned CW = $clog2(WAYS + 1);

    cap_e          eff;
    logic [CW-1:0] n_en;

    assign eff  = fold_cap(act_code, peer_active);
    assign n_en = CW'(ways_for(eff, WAYS));

    for (genvar i = 0; i < WAYS; i++) begin : g_way
        assign way_en[i] = (CW'(i) < n_en);
    end

    assign eff_code  = eff;
    assign sleep_req = peer_all_bypass && (!core_active || eff == CAP_BYPASS);

    p_sleep_peer_r9: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> peer_all_bypass);

    p_shared_full_r3: assert property (@(posedge clk) disable iff (rst)
        (peer_active && act_code != CAP_BYPASS) |-> (&way_en));

endmodule

// File: rtl/shc_txn_ctl.sv
module shc_txn_ctl
    import shc_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cap_e              eff_code,
    input  logic              hold,
    output logic              idle,
    input  logic              l1_req_valid,
    output logic              l1_req_ready,
    input  miss_req_t         l1_req,
    output logic              l2_req_valid,
    input  logic              l2_req_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output miss_req_t         down_req,
    input  logic              l2_rsp_valid,
    output logic              l2_rsp_ready,
    input  logic [DATA_W-1:0] l2_rsp_data,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              l1_rsp_valid,
    input  logic              l1_rsp_ready,
    output logic [DATA_W-1:0] l1_rsp_data
);
    tx_state_e st_q;
    path_e     tag_q;
    path_e     pick;
    logic      open_q;
    logic      waiting;

    assign pick    = (eff_code == CAP_BYPASS) ? PATH_MEM : PATH_SHARED;
    assign open_q  = (st_q == TX_IDLE) && !hold;
    assign waiting = (st_q == TX_WAIT);

    assign l2_req_valid  = open_q && l1_req_valid && (pick == PATH_SHARED);
    assign mem_req_valid = open_q && l1_req_valid && (pick == PATH_MEM);
    assign l1_req_ready  = open_q && ((pick == PATH_MEM) ? mem_req_ready : l2_req_ready);
    assign down_req      = l1_req;

    assign l1_rsp_valid  = waiting && ((tag_q == PATH_MEM) ? mem_rsp_valid : l2_rsp_valid);
    assign l1_rsp_data   = (tag_q == PATH_MEM) ? mem_rsp_data : l2_rsp_data;
    assign l2_rsp_ready  = waiting && (tag_q == PATH_SHARED) && l1_rsp_ready;
    assign mem_rsp_ready = waiting && (tag_q == PATH_MEM) && l1_rsp_ready;

    assign idle = (st_q == TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TX_IDLE;
            tag_q <= PATH_SHARED;
        end else begin
            case (st_q)
                TX_IDLE: if (l1_req_valid && l1_req_ready) begin
                    st_q  <= TX_WAIT;
                    tag_q <= pick;
                end
                TX_WAIT: if (l1_rsp_valid && l1_rsp_ready)
                    st_q <= TX_IDLE;
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    p_one_port_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !l2_req_valid);

    p_single_txn_r10: assert property (@(posedge clk) disable iff (rst)
        (l1_req_valid && l1_req_ready) |=> !l1_req_ready);

    p_tag_port_r8: assert property (@(posedge clk) disable iff (rst)
        (waiting && tag_q == PATH_MEM) |-> !l2_rsp_ready);

endmodule

// File: rtl/shc_route_top.sv
module shc_route_top
    import shc_route_pkg::*;
#(
    parameter int unsigned WAYS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_code,
    output logic [1:0]        cfg_rd_code,
    input  logic              core_active,
    input  logic              peer_active,
    input  logic              peer_all_bypass,
    input  logic              l1_req_valid,
    output logic              l1_req_ready,
    input  logic              l1_req_we,
    input  logic [ADDR_W-1:0] l1_req_addr,
    input  logic [DATA_W-1:0] l1_req_wdata,
    output logic              l2_req_valid,
    input  logic              l2_req_ready,
    output logic              l2_req_we,
    output logic [ADDR_W-1:0] l2_req_addr,
    output logic [DATA_W-1:0] l2_req_wdata,
    input  logic              l2_rsp_valid,
    output logic              l2_rsp_ready,
    input  logic [DATA_W-1:0] l2_rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              l1_rsp_valid,
    input  logic              l1_rsp_ready,
    output logic [DATA_W-1:0] l1_rsp_data,
    output logic [WAYS-1:0]   way_en,
    output logic              sleep_req
);
    cap_e      pend_code, act_code, eff_code;
    logic      switching, idle;
    miss_req_t up_req, dn_req;

    assign up_req = '{we: l1_req_we, addr: l1_req_addr, wdata: l1_req_wdata};

    shc_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr_en),
        .wr_code   (cap_e'(cfg_wr_code)),
        .idle      (idle),
        .pend_code (pend_code),
        .act_code  (act_code),
        .switching (switching)
    );

    shc_mode_map #(.WAYS(WAYS)) u_map (
        .clk             (clk),
        .rst             (rst),
        .act_code        (act_code),
        .core_active     (core_active),
        .peer_active     (peer_active),
        .peer_all_bypass (peer_all_bypass),
        .eff_code        (eff_code),
        .way_en          (way_en),
        .sleep_req       (sleep_req)
    );

    shc_txn_ctl u_txn (
        .clk           (clk),
        .rst           (rst),
        .eff_code      (eff_code),
        .hold          (switching),
        .idle          (idle),
        .l1_req_valid  (l1_req_valid),
        .l1_req_ready  (l1_req_ready),
        .l1_req        (up_req),
        .l2_req_valid  (l2_req_valid),
        .l2_req_ready  (l2_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .down_req      (dn_req),
        .l2_rsp_valid  (l2_rsp_valid),
        .l2_rsp_ready  (l2_rsp_ready),
        .l2_rsp_data   (l2_rsp_data),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_ready (mem_rsp_ready),
        .mem_rsp_data  (mem_rsp_data),
        .l1_rsp_valid  (l1_rsp_valid),
        .l1_rsp_ready  (l1_rsp_ready),
        .l1_rsp_data   (l1_rsp_data)
    );

    assign cfg_rd_code   = pend_code;
    assign l2_req_we     = dn_req.we;
    assign l2_req_addr   = dn_req.addr;
    assign l2_req_wdata  = dn_req.wdata;
    assign mem_req_we    = dn_req.we;
    assign mem_req_addr  = dn_req.addr;
    assign mem_req_wdata = dn_req.wdata;

    p_reset_full_r1: assert property (@(posedge clk)
        $past(rst) |-> (cfg_rd_code == 2'b00 && (&way_en)));

endmodule

// File: tb/sim_shc_route_top.sv
module sim_shc_route_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 0;
    logic [1:0]  cfg_wr_code = 0;
    logic [1:0]  cfg_rd_code;
    logic        core_active = 1, peer_active = 0, peer_all_bypass = 0;
    logic        l1_req_valid = 0, l1_req_we = 0;
    logic [31:0] l1_req_addr = 0, l1_req_wdata = 0;
    logic        l1_req_ready;
    logic        l2_req_valid, l2_req_we;
    logic [31:0] l2_req_addr, l2_req_wdata;
    logic        l2_req_ready = 0;
    logic        l2_rsp_valid = 0;
    logic        l2_rsp_ready;
    logic [31:0] l2_rsp_data = 0;
    logic        mem_req_valid, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_req_ready = 0;
    logic        mem_rsp_valid = 0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = 0;
    logic        l1_rsp_valid;
    logic        l1_rsp_ready = 0;
    logic [31:0] l1_rsp_data;
    logic [15:0] way_en;
    logic        sleep_req;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    int m_pend = 0, m_act = 0;
    bit m_busy = 0, m_mem = 0;

    always #5 clk = ~clk;

    shc_route_top u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff_of();
        if (peer_active && (m_act == 1 || m_act == 2)) return 0;
        return m_act;
    endfunction

    function automatic logic [15:0] mask_of(input int e);
        case (e)
            0: return 16'hFFFF;
            1: return 16'h00FF;
            2: return 16'h000F;
            default: return 16'h0000;
        endcase
    endfunction

    // Compare all outputs against the model, then advance one clock.
    task automatic tick();
        int  e;
        bit  open_ok, e_l2v, e_memv, e_rdy, e_rspv, e_l2r, e_memr, e_slp;
        logic [31:0] e_data;
        #2;
        e       = eff_of();
        open_ok = !m_busy && (m_pend == m_act);
        e_l2v   = open_ok && l1_req_valid && (e != 3);
        e_memv  = open_ok && l1_req_valid && (e == 3);
        e_rdy   = open_ok && ((e == 3) ? mem_req_ready : l2_req_ready);
        e_rspv  = m_busy && (m_mem ? mem_rsp_valid : l2_rsp_valid);
        e_data  = m_mem ? mem_rsp_data : l2_rsp_data;
        e_l2r   = m_busy && !m_mem && l1_rsp_ready;
        e_memr  = m_busy && m_mem && l1_rsp_ready;
        e_slp   = peer_all_bypass && (!core_active || e == 3);
        chk(way_en == mask_of(e), "R2 way_en", way_en, mask_of(e));
        chk(cfg_rd_code == 2'(m_pend), "R6 cfg_rd_code", cfg_rd_code, m_pend);
        chk(mem_req_valid == e_memv, "R4 mem_req_valid", mem_req_valid, e_memv);
        chk(l2_req_valid == e_l2v, "R5 l2_req_valid", l2_req_valid, e_l2v);
        chk(l1_req_ready == e_rdy, "R10 l1_req_ready", l1_req_ready, e_rdy);
        chk(l1_rsp_valid == e_rspv, "R8 l1_rsp_valid", l1_rsp_valid, e_rspv);
        chk(l2_rsp_ready == e_l2r, "R8 l2_rsp_ready", l2_rsp_ready, e_l2r);
        chk(mem_rsp_ready == e_memr, "R8 mem_rsp_ready", mem_rsp_ready, e_memr);
        chk(sleep_req == e_slp, "R9 sleep_req", sleep_req, e_slp);
        if (e_rspv)
            chk(l1_rsp_data == e_data, "R8 l1_rsp_data", l1_rsp_data, e_data);
        if (e_memv)
            chk(mem_req_addr == l1_req_addr && mem_req_wdata == l1_req_wdata && mem_req_we == l1_req_we,
                "R4 mem payload", mem_req_addr, l1_req_addr);
        if (e_l2v)
            chk(l2_req_addr == l1_req_addr && l2_req_wdata == l1_req_wdata && l2_req_we == l1_req_we,
                "R5 l2 payload", l2_req_addr, l1_req_addr);
        @(posedge clk);
        if (!m_busy && m_pend != m_act) m_act = m_pend;
        if (cfg_wr_en) m_pend = int'(cfg_wr_code);
        if (!m_busy) begin
            if (open_ok && l1_req_valid && e_rdy) begin
                m_busy = 1;
                m_mem  = (e == 3);
            end
        end else if (e_rspv && l1_rsp_ready) begin
            m_busy = 0;
        end
        @(negedge clk);
    endtask

    task automatic write_code(input logic [1:0] c);
        cfg_wr_en = 1; cfg_wr_code = c;
        tick();
        cfg_wr_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        // R1: reset state
        chk(cfg_rd_code == 2'b00, "R1 code after reset", cfg_rd_code, 0);
        chk(way_en == 16'hFFFF, "R1 mask after reset", way_en, 16'hFFFF);
        chk(!l2_req_valid && !mem_req_valid, "R1 no request", {l2_req_valid, mem_req_valid}, 0);
        @(negedge clk);

        // R2: each code alone
        write_code(2'b01); tick(); tick();
        chk(way_en == 16'h00FF, "R2 half mask", way_en, 16'h00FF);
        write_code(2'b10); tick(); tick();
        chk(way_en == 16'h000F, "R2 quarter mask", way_en, 16'h000F);
        // R3: peer active folds quarter to full
        peer_active = 1; tick();
        chk(way_en == 16'hFFFF, "R3 quarter with peer", way_en, 16'hFFFF);
        l1_req_valid = 1; l1_req_addr = 32'h1000; l2_req_ready = 1;
        #1;
        chk(l2_req_valid && !mem_req_valid, "R3 routes to shared", {l2_req_valid, mem_req_valid}, 2'b10);
        tick();
        l1_req_valid = 0; l2_req_ready = 0;
        l2_rsp_valid = 1; l2_rsp_data = 32'hA5A5_0001; l1_rsp_ready = 1;
        tick();
        l2_rsp_valid = 0; l1_rsp_ready = 0; peer_active = 0;

        // R4: bypass round trip with sleep request
        write_code(2'b11); tick(); tick();
        peer_all_bypass = 1;
        l1_req_valid = 1; l1_req_addr = 32'h2040; l1_req_we = 1; l1_req_wdata = 32'hDEAD; mem_req_ready = 1;
        tick();
        l1_req_valid = 0; mem_req_ready = 0; l1_req_we = 0;
        tick();
        mem_rsp_valid = 1; mem_rsp_data = 32'h0BAD_F00D; l1_rsp_ready = 1;
        tick();
        mem_rsp_valid = 0; l1_rsp_ready = 0; peer_all_bypass = 0;

        // R7 / R8: switch code while a shared-cache request is outstanding
        write_code(2'b00); tick();
        l1_req_valid = 1; l1_req_addr = 32'h3000; l2_req_ready = 1;
        tick();
        l2_req_ready = 0;
        write_code(2'b11);
        mem_rsp_valid = 1; mem_rsp_data = 32'h1111; mem_req_ready = 1; l1_rsp_ready = 1;
        #1;
        chk(way_en == 16'hFFFF, "R7 mask held during txn", way_en, 16'hFFFF);
        chk(!l1_req_ready, "R7 stall during switch", l1_req_ready, 0);
        chk(!mem_rsp_ready, "R8 stray mem response ignored", mem_rsp_ready, 0);
        tick(); tick();
        l2_rsp_valid = 1; l2_rsp_data = 32'h2222;
        tick();
        l2_rsp_valid = 0; mem_rsp_valid = 0;
        tick(); tick();
        chk(way_en == 16'h0000, "R7 bypass after commit", way_en, 0);
        l1_req_valid = 0; l1_rsp_ready = 0; mem_req_ready = 0;
        tick();

        // random phase
        for (int k = 0; k < 4000; k++) begin
            cfg_wr_en       = ($urandom % 16) == 0;
            cfg_wr_code     = 2'($urandom);
            core_active     = ($urandom % 4) != 0;
            peer_active     = ($urandom % 3) == 0;
            peer_all_bypass = $urandom % 2;
            l1_req_valid    = $urandom % 2;
            l1_req_we       = $urandom % 2;
            l1_req_addr     = $urandom;
            l1_req_wdata    = $urandom;
            l2_req_ready    = $urandom % 2;
            mem_req_ready   = $urandom % 2;
            l2_rsp_valid    = $urandom % 2;
            mem_rsp_valid   = $urandom % 2;
            l2_rsp_data     = $urandom;
            mem_rsp_data    = $urandom;
            l1_rsp_ready    = $urandom % 2;
            tick();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule